// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two 16-bit count units. Each unit is split into a low byte and a high byte. The units run from a machine-cycle tick that the block derives from its clock. A unit increments either once per machine cycle (timer) or once for each falling edge seen on its external count pin (counter). A run bit enables counting. An optional gate input also makes counting depend on a second pin being high. A mode byte holds a four-bit configuration for each unit, and a control byte holds the run bits and the two overflow flags. Both are written through a small byte-wide write port, and so are the four count bytes.

Each unit has four modes:
- a 13-bit mode, in which a 5-bit prescaler in the low byte feeds the high byte;
- a full 16-bit mode;
- an 8-bit mode with automatic reload, in which the high byte holds the reload value;
- a split mode.

In split mode, unit 0 becomes two independent 8-bit counters, and its high byte borrows unit 1's run bit and overflow flag. Unit 1 placed in the split mode stands still. Each overflow flag has a hardware acknowledge input that clears it.

Top module: `dual_timer_counter`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all count bytes, both run bits, both flags and the mode byte are zero.
- R2: A machine-cycle tick occurs on every MC_DIV-th clock (default 12). The first tick is on the MC_DIV-th clock edge after reset is released. In timer mode an enabled unit advances exactly once per tick.
- R3: A unit counts only while its run bit is 1 and, if its gate bit is 1, its gate pin is high.
- R4: In counter mode, the count pin is sampled at each tick. A unit advances by one at a tick whose sample is 0 when the previous tick's sample was 1. The sample register resets to 0.
- R5: In mode 0 (13-bit), bits 4:0 of the low byte count. When they pass from 31 to 0 the high byte increments, and the flag is set when the high byte rolls from FFh to 00h. Bits 7:5 of the low byte keep their value.
- R6: In mode 1, the high and low bytes form one 16-bit counter, and the flag is set when it rolls from FFFFh to 0000h.
- R7: In mode 2, the low byte counts. On a count at FFh the low byte loads the high byte, the flag is set, and the high byte is unchanged.
- R8: In mode 3, unit 0's low byte counts under unit 0's run bit, gate and source and sets flag 0. Its high byte counts every tick while run bit 1 is set, and sets flag 1 on rolling from FFh.
- R9: Unit 1 in mode 3 holds its count. While unit 0 is in mode 3, unit 1 in modes 0 to 2 counts without regard to run bit 1 and never sets flag 1.
- R10: A flag is set by its overflow and cleared by its acknowledge input. A same-cycle overflow wins over the acknowledge. A control write loads both flags and both run bits and wins over both.
- R11: A write to a count byte takes effect in place of any same-cycle increment of that byte.
- R12: Write select codes: 0 mode, 1 control, 2 low byte 0, 3 high byte 0, 4 low byte 1, 5 high byte 1. Mode byte: unit 0 uses bits 3:0 and unit 1 uses bits 7:4; within a nibble, bit 3 is gate, bit 2 selects counter mode, and bits 1:0 are the mode. Control byte: bit 0 run 0, bit 1 run 1, bit 2 flag 0, bit 3 flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | 8 | Write data |
| cnt_pin0_i | input | 1 | External count pin, unit 0 |
| cnt_pin1_i | input | 1 | External count pin, unit 1 |
| gate_pin0_i | input | 1 | Gate pin, unit 0 |
| gate_pin1_i | input | 1 | Gate pin, unit 1 |
| ack0_i | input | 1 | Clear flag 0 |
| ack1_i | input | 1 | Clear flag 1 |
| cnt0_o | output | 16 | Unit 0 count {high, low} |
| cnt1_o | output | 16 | Unit 1 count {high, low} |
| flag0_o | output | 1 | Overflow flag 0 |
| flag1_o | output | 1 | Overflow flag 1 |

## Verification
The bench preloads counts just short of each rollover. A prescaler that carried at the wrong bit would advance the high byte early. A reload that touched the high byte would change the reload value. Split mode is run with run bit 1 both on and off, which exposes a high byte that stays tied to unit 1 and a unit 1 that wrongly keeps setting flag 1. Acknowledge pulses, control writes and byte writes are aimed at the exact tick of an overflow or increment, so a wrong priority leaves a stale flag or a count that is one too high.

// File: rtl/tc_pkg.sv
package tc_pkg;
    // Operating mode of one count unit.
    typedef enum logic [1:0] {
        M_PRE13   = 2'd0,
        M_FULL16  = 2'd1,
        M_RELOAD8 = 2'd2,
        M_SPLIT   = 2'd3
    } tc_mode_e;

    // One configuration nibble: gate, source, mode.
    typedef struct packed {
        logic     gate;
        logic     ext_cnt;
        tc_mode_e mode;
    } tc_cfg_t;

    localparam logic [2:0] SEL_MODE = 3'd0;
    localparam logic [2:0] SEL_CTRL = 3'd1;
    localparam logic [2:0] SEL_LO0  = 3'd2;
    localparam logic [2:0] SEL_HI0  = 3'd3;
    localparam logic [2:0] SEL_LO1  = 3'd4;
    localparam logic [2:0] SEL_HI1  = 3'd5;

    localparam int CB_RUN0 = 0;
    localparam int CB_RUN1 = 1;
    localparam int CB_FLG0 = 2;
    localparam int CB_FLG1 = 3;
endpackage

// File: rtl/tc_tick_gen.sv
// Machine-cycle tick generator.
// Raises tick_o for one clock out of every DIV; the first tick comes on the
// DIV-th edge after reset is released. Assumes DIV >= 2.
module tc_tick_gen #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] div_q;

    // The tick fires while the divider sits at its last state.
    assign tick_o = (div_q == CW'(DIV - 1));

    // Divider that wraps after DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= tick_o ? '0 : div_q + 1'b1;
    end

    // R2: ticks are never on adjacent clocks.
    a_r2_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/tc_edge_sample.sv
// Falling-edge detector for an external count pin.
// Samples the pin at each tick and flags a high-then-low pair of samples.
// Assumes the pin is already synchronous to clk.
module tc_edge_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pin_i,
    output logic fall_o
);
    logic samp_q;

    // A count is due when the last sample was high and the pin is now low.
    assign fall_o = tick_i & samp_q & ~pin_i;

    // Hold the sample taken at the latest tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      samp_q <= 1'b0;
        else if (tick_i) samp_q <= pin_i;
    end

    // R4: an edge is only reported on a tick.
    a_r4_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> tick_i);
endmodule

// File: rtl/tc_unit.sv
// One count unit: a low byte and a high byte that are stepped according to
// the mode. SPLIT=1 lets mode 3 run the two bytes separately (the high byte
// from inc_hi_i); SPLIT=0 makes mode 3 hold both bytes. A byte write
// replaces the byte's next value.
module tc_unit
    import tc_pkg::*;
#(
    parameter int BW    = 8,
    parameter int PRE   = 5,
    parameter bit SPLIT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tc_mode_e      mode_i,
    input  logic          inc_i,
    input  logic          inc_hi_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [BW-1:0] wr_data_i,
    output logic [BW-1:0] lo_o,
    output logic [BW-1:0] hi_o,
    output logic          ovf_o,
    output logic          ovf_hi_o
);
    logic [BW-1:0] lo_q, hi_q, nxt_lo, nxt_hi;

    // Next count and overflow for the current mode.
    always_comb begin
        nxt_lo   = lo_q;
        nxt_hi   = hi_q;
        ovf_o    = 1'b0;
        ovf_hi_o = 1'b0;
        unique case (mode_i)
            M_PRE13: if (inc_i) begin
                nxt_lo[PRE-1:0] = lo_q[PRE-1:0] + 1'b1;
                if (&lo_q[PRE-1:0]) begin
                    nxt_hi = hi_q + 1'b1;
                    ovf_o  = &hi_q;
                end
            end
            M_FULL16: if (inc_i) begin
                {nxt_hi, nxt_lo} = {hi_q, lo_q} + 1'b1;
                ovf_o = &{hi_q, lo_q};
            end
            M_RELOAD8: if (inc_i) begin
                if (&lo_q) begin
                    nxt_lo = hi_q;
                    ovf_o  = 1'b1;
                end else begin
                    nxt_lo = lo_q + 1'b1;
                end
            end
            M_SPLIT: if (SPLIT) begin
                if (inc_i) begin
                    nxt_lo = lo_q + 1'b1;
                    ovf_o  = &lo_q;
                end
                if (inc_hi_i) begin
                    nxt_hi   = hi_q + 1'b1;
                    ovf_hi_o = &hi_q;
                end
            end
            default: ;
        endcase
    end

    // Count registers; a write wins over the increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= wr_lo_i ? wr_data_i : nxt_lo;
            hi_q <= wr_hi_i ? wr_data_i : nxt_hi;
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;

    // R5: a full prescaler carries into the high byte and keeps the top bits.
    a_r5_prescale_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_PRE13 && inc_i && (&lo_q[PRE-1:0]) && !wr_lo_i && !wr_hi_i)
        |=> (lo_q[PRE-1:0] == '0 && hi_q == BW'($past(hi_q) + 1'b1)
             && lo_q[BW-1:PRE] == $past(lo_q[BW-1:PRE])));

    // R6: the full mode advances the 16-bit value by one.
    a_r6_full_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_FULL16 && inc_i && !wr_lo_i && !wr_hi_i)
        |=> ({hi_q, lo_q} == (2*BW)'($past({hi_q, lo_q}) + 1'b1)));

    // R7: a rollover in reload mode copies the high byte and leaves it alone.
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_RELOAD8 && inc_i && (&lo_q) && !wr_lo_i && !wr_hi_i)
        |=> (lo_q == $past(hi_q) && hi_q == $past(hi_q)));

    // R11: a written byte shows the written data.
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> (lo_q == $past(wr_data_i)));

    generate
        if (!SPLIT) begin : g_freeze
            // R9: a unit without split support stands still in mode 3.
            a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i == M_SPLIT && !wr_lo_i && !wr_hi_i)
                |=> ($stable(lo_q) && $stable(hi_q)));
        end
    endgenerate
endmodule

// File: rtl/dual_timer_counter.sv
// Two count units with a shared mode byte and control byte.
// Derives the machine-cycle tick, forms each unit's count enable from its
// run bit, gate and source, and routes the overflows to the two flags.
// In split mode unit 0's high byte takes run bit 1 and flag 1.
// Assumes every pin input is already synchronous to clk.
module dual_timer_counter
    import tc_pkg::*;
#(
    parameter int MC_DIV = 12,
    parameter int BW     = 8,
    parameter int PRE    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [2:0]    wr_sel_i,
    input  logic [BW-1:0] wr_data_i,
    input  logic          cnt_pin0_i,
    input  logic          cnt_pin1_i,
    input  logic          gate_pin0_i,
    input  logic          gate_pin1_i,
    input  logic          ack0_i,
    input  logic          ack1_i,
    output logic [2*BW-1:0] cnt0_o,
    output logic [2*BW-1:0] cnt1_o,
    output logic          flag0_o,
    output logic          flag1_o
);
    localparam int NU = 2;

    logic [BW-1:0] mode_q;
    logic          run0_q, run1_q, flag0_q, flag1_q;
    logic          tick;
    logic [NU-1:0] fall, pins;
    tc_cfg_t       cfg0, cfg1;
    logic          split, run1_eff, inc0, inc1, inc_hi0;
    logic          ovf0, ovf0_hi, ovf1, ovf1_hi, set0, set1;
    logic          wr_mode, wr_ctrl;
    logic [BW-1:0] lo0, hi0, lo1, hi1;

    tc_tick_gen #(.DIV(MC_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    assign pins = {cnt_pin1_i, cnt_pin0_i};

    generate
        for (genvar g = 0; g < NU; g++) begin : g_edge
            tc_edge_sample u_edge (
                .clk(clk), .rst_n(rst_n), .tick_i(tick),
                .pin_i(pins[g]), .fall_o(fall[g])
            );
        end
    endgenerate

    // Decode the mode nibbles and form the count enables.
    always_comb begin
        cfg0     = tc_cfg_t'(mode_q[3:0]);
        cfg1     = tc_cfg_t'(mode_q[7:4]);
        split    = (cfg0.mode == M_SPLIT);
        run1_eff = split | run1_q;
        inc0     = run0_q & (~cfg0.gate | gate_pin0_i) & (cfg0.ext_cnt ? fall[0] : tick);
        inc1     = run1_eff & (~cfg1.gate | gate_pin1_i) & (cfg1.ext_cnt ? fall[1] : tick);
        inc_hi0  = split & run1_q & tick;
        set0     = ovf0;
        set1     = split ? ovf0_hi : ovf1;
        wr_mode  = wr_en_i && wr_sel_i == SEL_MODE;
        wr_ctrl  = wr_en_i && wr_sel_i == SEL_CTRL;
    end

    tc_unit #(.BW(BW), .PRE(PRE), .SPLIT(1'b1)) u_unit0 (
        .clk(clk), .rst_n(rst_n), .mode_i(cfg0.mode),
        .inc_i(inc0), .inc_hi_i(inc_hi0),
        .wr_lo_i(wr_en_i && wr_sel_i == SEL_LO0),
        .wr_hi_i(wr_en_i && wr_sel_i == SEL_HI0),
        .wr_data_i(wr_data_i), .lo_o(lo0), .hi_o(hi0),
        .ovf_o(ovf0), .ovf_hi_o(ovf0_hi)
    );

    tc_unit #(.BW(BW), .PRE(PRE), .SPLIT(1'b0)) u_unit1 (
        .clk(clk), .rst_n(rst_n), .mode_i(cfg1.mode),
        .inc_i(inc1), .inc_hi_i(1'b0),
        .wr_lo_i(wr_en_i && wr_sel_i == SEL_LO1),
        .wr_hi_i(wr_en_i && wr_sel_i == SEL_HI1),
        .wr_data_i(wr_data_i), .lo_o(lo1), .hi_o(hi1),
        .ovf_o(ovf1), .ovf_hi_o(ovf1_hi)
    );

    // Mode byte, run bits and flags; a control write wins over set and ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            run0_q  <= 1'b0;
            run1_q  <= 1'b0;
            flag0_q <= 1'b0;
            flag1_q <= 1'b0;
        end else begin
            if (wr_mode) mode_q <= wr_data_i;
            if (wr_ctrl) begin
                run0_q  <= wr_data_i[CB_RUN0];
                run1_q  <= wr_data_i[CB_RUN1];
                flag0_q <= wr_data_i[CB_FLG0];
                flag1_q <= wr_data_i[CB_FLG1];
            end else begin
                flag0_q <= set0 | (flag0_q & ~ack0_i);
                flag1_q <= set1 | (flag1_q & ~ack1_i);
            end
        end
    end

    assign cnt0_o  = {hi0, lo0};
    assign cnt1_o  = {hi1, lo1};
    assign flag0_o = flag0_q;
    assign flag1_o = flag1_q;

    // R10: acknowledge without a competing set clears the flag.
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack0_i && !set0 && !wr_ctrl) |=> !flag0_o);

    // R10: an overflow sets its flag even against an acknowledge.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set1 && !wr_ctrl) |=> flag1_o);

    // R9: in split mode unit 1 never reaches flag 1.
    a_r9_no_flag_steal: assert property (@(posedge clk) disable iff (!rst_n)
        (split && !ovf0_hi && !wr_ctrl && !flag1_o) |=> !flag1_o);

    // R3: with run bit 0 clear, unit 0 holds its count.
    a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run0_q && cfg0.mode != M_SPLIT && !(wr_en_i && (wr_sel_i == SEL_LO0 || wr_sel_i == SEL_HI0)))
        |=> $stable(cnt0_o));
endmodule

// File: tb/test_dual_timer_counter.sv
module test_dual_timer_counter;
    localparam int DIV = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        pin0 = 1'b0, pin1 = 1'b0, gp0 = 1'b0, gp1 = 1'b0;
    logic        ack0 = 1'b0, ack1 = 1'b0;
    logic [15:0] cnt0, cnt1;
    logic        flag0, flag1;

    int n_chk = 0, n_bad = 0, clk_cnt = 0;
    string cur_req = "R1";

    // Reference state
    int         m_div;
    logic [7:0] m_mode, m_lo [2], m_hi [2];
    logic       m_run0, m_run1, m_f0, m_f1;
    logic       m_samp [2];

    dual_timer_counter i_dual_timer_counter (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .cnt_pin0_i(pin0), .cnt_pin1_i(pin1),
        .gate_pin0_i(gp0), .gate_pin1_i(gp1), .ack0_i(ack0), .ack1_i(ack1),
        .cnt0_o(cnt0), .cnt1_o(cnt1), .flag0_o(flag0), .flag1_o(flag1)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        clk_cnt++;
        if (clk_cnt > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog %s actual running expected finished", cur_req);
            summary();
            $finish;
        end
    end

    // One unit step as the requirements define it.
    task automatic ustep(input logic [1:0] md, input bit can_split, input bit inc,
                         input bit inc_hi, inout logic [7:0] l, inout logic [7:0] h,
                         output bit ov, output bit ovh);
        ov = 0; ovh = 0;
        case (md)
            2'd0: if (inc) begin
                if (l[4:0] == 5'h1f) begin ov = (h == 8'hff); h = h + 8'd1; end
                l[4:0] = l[4:0] + 5'd1;
            end
            2'd1: if (inc) begin
                ov = ({h, l} == 16'hffff);
                {h, l} = {h, l} + 16'd1;
            end
            2'd2: if (inc) begin
                if (l == 8'hff) begin l = h; ov = 1; end
                else l = l + 8'd1;
            end
            default: if (can_split) begin
                if (inc) begin ov = (l == 8'hff); l = l + 8'd1; end
                if (inc_hi) begin ovh = (h == 8'hff); h = h + 8'd1; end
            end
        endcase
    endtask

    task automatic model_step();
        bit tick, f0, f1, split, r1e, i0, i1, ih, o0, oh0, o1, oh1, s0, s1;
        logic [7:0] l0, h0, l1, h1;
        if (!rst_n) begin
            m_div = 0; m_mode = 0; m_run0 = 0; m_run1 = 0; m_f0 = 0; m_f1 = 0;
            m_lo[0] = 0; m_lo[1] = 0; m_hi[0] = 0; m_hi[1] = 0;
            m_samp[0] = 0; m_samp[1] = 0;
            return;
        end
        tick = (m_div == DIV - 1);
        m_div = tick ? 0 : m_div + 1;
        f0 = tick & m_samp[0] & ~pin0;
        f1 = tick & m_samp[1] & ~pin1;
        if (tick) begin m_samp[0] = pin0; m_samp[1] = pin1; end
        split = (m_mode[1:0] == 2'd3);
        r1e = split | m_run1;
        i0 = m_run0 & (~m_mode[3] | gp0) & (m_mode[2] ? f0 : tick);
        i1 = r1e & (~m_mode[7] | gp1) & (m_mode[6] ? f1 : tick);
        ih = split & m_run1 & tick;
        l0 = m_lo[0]; h0 = m_hi[0]; l1 = m_lo[1]; h1 = m_hi[1];
        ustep(m_mode[1:0], 1, i0, ih, l0, h0, o0, oh0);
        ustep(m_mode[5:4], 0, i1, 0, l1, h1, o1, oh1);
        s0 = o0; s1 = split ? oh0 : o1;
        if (wr_en) case (wr_sel)
            3'd2: l0 = wr_data;
            3'd3: h0 = wr_data;
            3'd4: l1 = wr_data;
            3'd5: h1 = wr_data;
            default: ;
        endcase
        m_lo[0] = l0; m_hi[0] = h0; m_lo[1] = l1; m_hi[1] = h1;
        if (wr_en && wr_sel == 3'd1) begin
            m_run0 = wr_data[0]; m_run1 = wr_data[1]; m_f0 = wr_data[2]; m_f1 = wr_data[3];
        end else begin
            m_f0 = s0 | (m_f0 & ~ack0);
            m_f1 = s1 | (m_f1 & ~ack1);
        end
        if (wr_en && wr_sel == 3'd0) m_mode = wr_data;
    endtask

    task automatic compare();
        bit bad = 0;
        n_chk++;
        if (cnt0 !== {m_hi[0], m_lo[0]}) begin bad = 1;
            $display("FAIL %s cnt0 actual %h expected %h", cur_req, cnt0, {m_hi[0], m_lo[0]}); end
        if (cnt1 !== {m_hi[1], m_lo[1]}) begin bad = 1;
            $display("FAIL %s cnt1 actual %h expected %h", cur_req, cnt1, {m_hi[1], m_lo[1]}); end
        if (flag0 !== m_f0) begin bad = 1;
            $display("FAIL %s flag0 actual %b expected %b", cur_req, flag0, m_f0); end
        if (flag1 !== m_f1) begin bad = 1;
            $display("FAIL %s flag1 actual %b expected %b", cur_req, flag1, m_f1); end
        if (bad) n_bad++;
    endtask

    // Advance one clock: model, edge, compare at the falling edge.
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        wr_en = 0; ack0 = 0; ack1 = 0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        cyc();
    endtask

    task automatic run_mc(input int n);
        repeat (n * DIV) cyc();
    endtask

    task automatic check_val(input string req, input logic [15:0] act, input logic [15:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp_v);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0017));
        @(negedge clk);
        repeat (3) cyc();
        cur_req = "R1";
        compare();
        check_val("R1", {cnt0 | cnt1, 14'd0, flag0, flag1}, 32'd0);
        rst_n = 1;

        cur_req = "R2";                          // timer mode, 16-bit both units
        wr(3'd0, 8'h11);
        wr(3'd1, 8'h03);
        run_mc(40);

        cur_req = "R3";                          // gated, gate pins toggled
        wr(3'd0, 8'h99);
        for (int k = 0; k < 60; k++) begin
            gp0 = k[1]; gp1 = k[2];
            run_mc(1);
        end
        wr(3'd1, 8'h02);                         // run 0 off
        run_mc(10);

        cur_req = "R4";                          // counter mode with pin patterns
        wr(3'd0, 8'h55);
        wr(3'd1, 8'h03);
        for (int k = 0; k < 80; k++) begin
            pin0 = ~pin0;
            pin1 = (k % 3 == 0);
            run_mc(1);
        end
        for (int k = 0; k < 40; k++) begin
            pin0 = $urandom_range(0, 1); pin1 = $urandom_range(0, 1);
            repeat ($urandom_range(1, 30)) cyc();
        end

        cur_req = "R5";                          // 13-bit mode near rollover
        wr(3'd0, 8'h00);
        wr(3'd3, 8'hff); wr(3'd2, 8'he0 | 8'h1c);
        wr(3'd5, 8'hfe); wr(3'd4, 8'h5e);
        run_mc(80);

        cur_req = "R6";
        wr(3'd0, 8'h11);
        wr(3'd3, 8'hff); wr(3'd2, 8'hf0);
        wr(3'd5, 8'hff); wr(3'd4, 8'hfa);
        run_mc(30);

        cur_req = "R7";
        wr(3'd0, 8'h22);
        wr(3'd3, 8'hf0); wr(3'd2, 8'hfa);
        wr(3'd5, 8'h80); wr(3'd4, 8'hfd);
        run_mc(60);

        cur_req = "R10";
        ack0 = 1; ack1 = 1; cyc();
        run_mc(3);
        wr(3'd1, 8'h0f);
        ack0 = 1; cyc();
        wr(3'd1, 8'h03);
        while (m_div != DIV - 1 || m_lo[0] != 8'hff) cyc();
        ack0 = 1; cyc();                         // overflow beats ack

        cur_req = "R8";                          // split mode, run 1 on then off
        wr(3'd1, 8'h03);
        wr(3'd0, 8'h03);
        wr(3'd2, 8'hf8); wr(3'd3, 8'hfc);
        run_mc(30);
        wr(3'd1, 8'h01);
        run_mc(20);

        cur_req = "R9";                          // unit 1 frozen, then free-running
        wr(3'd0, 8'h33);
        run_mc(20);
        wr(3'd0, 8'h13);
        wr(3'd5, 8'hff); wr(3'd4, 8'hfe);
        run_mc(20);

        cur_req = "R11";                         // write lands on a tick
        wr(3'd0, 8'h11);
        wr(3'd1, 8'h03);
        while (m_div != DIV - 1) cyc();
        wr(3'd2, 8'h42);
        check_val("R11", {8'd0, cnt0[7:0]}, 16'h0042);

        cur_req = "R12";                         // random mix of all controls
        for (int k = 0; k < 24000; k++) begin
            if ($urandom_range(0, 40) == 0) begin
                wr_en = 1; wr_sel = 3'($urandom_range(0, 5)); wr_data = 8'($urandom);
            end
            if ($urandom_range(0, 15) == 0) pin0 = ~pin0;
            if ($urandom_range(0, 15) == 0) pin1 = ~pin1;
            if ($urandom_range(0, 25) == 0) gp0 = ~gp0;
            if ($urandom_range(0, 25) == 0) gp1 = ~gp1;
            ack0 = ($urandom_range(0, 60) == 0);
            ack1 = ($urandom_range(0, 60) == 0);
            cyc();
        end

        summary();
        $finish;
    end
endmodule